// File: doc/BRIEF.md
# FIFO Fill-Level Interrupt Generator

This block watches the occupancy of four FIFOs that sit next to a serial bus controller: a command (format) queue, a receive queue, a target-side transmit queue and a target-side acquire queue. Each FIFO holds up to `DEPTH` entries and reports its occupancy as a count from 0 to `DEPTH`. From these counts, and from the write attempts made on three of the queues, the block derives the interrupt conditions a controller needs. It raises one-cycle pulses when a watermark is crossed or when a write is lost to a full queue. It holds a level while the acquire queue is full. It also turns a write-one-to-clear request into one-cycle clear strobes for the FIFOs.

The watermarks for the receive and command queues come from small code tables. The receive queue fires when its occupancy rises above the selected mark. The command queue fires when its occupancy drops below its mark. Every output is registered, so each output reflects the inputs sampled at the previous rising clock edge. The reset is asserted asynchronously and released through a two-flop synchronizer.

Top module: `fifo_irq_gen`

## Requirements
- R1: The 3-bit receive watermark code selects 1, 4, 8, 16 or 30 entries for codes 0, 1, 2, 3 and 4. Codes 5, 6 and 7 select 30 entries.
- R2: `rx_above_o` is high in the cycle after a clock edge at which the receive occupancy was strictly greater than the selected receive watermark. It is low in that cycle otherwise.
- R3: The 2-bit command watermark code selects 1, 4, 8 or 16 entries for codes 0, 1, 2 and 3.
- R4: `fmt_below_o` is high in the cycle after a clock edge at which the command occupancy was strictly less than the selected command watermark. It is low in that cycle otherwise.
- R5: `rx_thr_evt_o` and `fmt_thr_evt_o` pulse for exactly one cycle, in the cycle their status output rises. They stay low while the status output remains high.
- R6: While reset is held, and in the cycles after its release with empty FIFOs, `fmt_below_o` is 1. All other outputs are 0, and no watermark pulse is produced.
- R7: `fmt_ovf_evt_o`, `rx_ovf_evt_o` and `tx_ovf_evt_o` pulse in the cycle after an edge at which the matching write attempt was high while that occupancy equalled `DEPTH`. They are low after any other edge.
- R8: `acq_full_o` is high in every cycle after an edge at which the acquire occupancy equalled `DEPTH`, and low otherwise.
- R9: When `clr_wr_i` is high at an edge, `clr_o` equals `clr_bits_i` for the following cycle only (bit 0 command, bit 1 receive, bit 2 transmit, bit 3 acquire). `clr_bits_i` has no effect when `clr_wr_i` is low, so the strobes read back as 0 at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fmt_lvl_i | input | LW | Command FIFO occupancy |
| rx_lvl_i | input | LW | Receive FIFO occupancy |
| tx_lvl_i | input | LW | Transmit FIFO occupancy |
| acq_lvl_i | input | LW | Acquire FIFO occupancy |
| fmt_wr_i | input | 1 | Write attempt on the command FIFO |
| rx_wr_i | input | 1 | Write attempt on the receive FIFO |
| tx_wr_i | input | 1 | Write attempt on the transmit FIFO |
| rx_thr_code_i | input | 3 | Receive watermark code |
| fmt_thr_code_i | input | 2 | Command watermark code |
| clr_wr_i | input | 1 | Write strobe of the clear bits |
| clr_bits_i | input | 4 | Write-one-to-clear bits, one per FIFO |
| rx_above_o | output | 1 | Receive occupancy above watermark (level) |
| fmt_below_o | output | 1 | Command occupancy below watermark (level) |
| rx_thr_evt_o | output | 1 | Receive watermark crossing pulse |
| fmt_thr_evt_o | output | 1 | Command watermark crossing pulse |
| fmt_ovf_evt_o | output | 1 | Write lost to full command FIFO |
| rx_ovf_evt_o | output | 1 | Write lost to full receive FIFO |
| tx_ovf_evt_o | output | 1 | Write lost to full transmit FIFO |
| acq_full_o | output | 1 | Acquire FIFO full (level) |
| clr_o | output | 4 | One-cycle clear strobes, one per FIFO |

## Verification
The cycle-by-cycle properties bound to the block cover several rules on every cycle. A watermark pulse always coincides with its status level and never lasts two cycles. An overflow pulse always follows a write attempt. The full flag tracks the acquire occupancy one edge later. Clear strobes only follow a clear write and only carry bits that were written.

The contents of the two watermark tables, the strict direction of each comparison at its boundary, and the mapping of the unused receive codes are shown only by the bench's directed sweeps. The same holds for the quiet start after reset and for a lost write being reported only at exactly full occupancy.

// File: rtl/fifo_irq_pkg.sv
package fifo_irq_pkg;

  // Clear-strobe bit positions
  localparam int unsigned IDX_FMT = 0;
  localparam int unsigned IDX_RX  = 1;
  localparam int unsigned IDX_TX  = 2;
  localparam int unsigned IDX_ACQ = 3;
  localparam int unsigned NUM_FIFO = 4;

  // Receive watermark table; unused codes fall back to the top entry
  function automatic int unsigned rx_mark(input logic [2:0] code);
    case (code)
      3'd0:    return 1;
      3'd1:    return 4;
      3'd2:    return 8;
      3'd3:    return 16;
      default: return 30;
    endcase
  endfunction

  // Command watermark table
  function automatic int unsigned fmt_mark(input logic [1:0] code);
    case (code)
      2'd0:    return 1;
      2'd1:    return 4;
      2'd2:    return 8;
      default: return 16;
    endcase
  endfunction

endpackage

// File: rtl/fiq_rst_sync.sv
module fiq_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/fiq_thresh.sv
module fiq_thresh #(
  parameter int unsigned LW    = 7,
  parameter bit          ABOVE = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [LW-1:0] lvl_i,
  input  logic [LW-1:0] mark_i,
  output logic          cond_o,
  output logic          evt_o
);
  // Condition value for an empty FIFO, used as the reset state
  localparam bit RST_COND = ABOVE ? 1'b0 : 1'b1;

  logic cond_d, cond_q;
  logic evt_d, evt_q;

  generate
    if (ABOVE) begin : g_above
      assign cond_d = (lvl_i > mark_i);
    end else begin : g_below
      assign cond_d = (lvl_i < mark_i);
    end
  endgenerate

  always_comb begin
    evt_d = cond_d & ~cond_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cond_q <= RST_COND;
      evt_q  <= 1'b0;
    end else begin
      cond_q <= cond_d;
      evt_q  <= evt_d;
    end
  end

  assign cond_o = cond_q;
  assign evt_o  = evt_q;
endmodule

// File: rtl/fiq_ovf.sv
module fiq_ovf #(
  parameter int unsigned N     = 3,
  parameter int unsigned DEPTH = 64,
  parameter int unsigned LW    = 7
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [N-1:0][LW-1:0]  lvl_i,
  input  logic [N-1:0]          wr_i,
  output logic [N-1:0]          ovf_o
);
  localparam logic [LW-1:0] FULL = LW'(DEPTH);

  logic [N-1:0] ovf_d, ovf_q;

  for (genvar i = 0; i < N; i++) begin : g_ch
    assign ovf_d[i] = wr_i[i] & (lvl_i[i] == FULL);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ovf_q <= '0;
    else         ovf_q <= ovf_d;
  end

  assign ovf_o = ovf_q;
endmodule

// File: rtl/fifo_irq_gen.sv
module fifo_irq_gen
  import fifo_irq_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [LW-1:0] fmt_lvl_i,
  input  logic [LW-1:0] rx_lvl_i,
  input  logic [LW-1:0] tx_lvl_i,
  input  logic [LW-1:0] acq_lvl_i,
  input  logic          fmt_wr_i,
  input  logic          rx_wr_i,
  input  logic          tx_wr_i,
  input  logic [2:0]    rx_thr_code_i,
  input  logic [1:0]    fmt_thr_code_i,
  input  logic          clr_wr_i,
  input  logic [3:0]    clr_bits_i,
  output logic          rx_above_o,
  output logic          fmt_below_o,
  output logic          rx_thr_evt_o,
  output logic          fmt_thr_evt_o,
  output logic          fmt_ovf_evt_o,
  output logic          rx_ovf_evt_o,
  output logic          tx_ovf_evt_o,
  output logic          acq_full_o,
  output logic [3:0]    clr_o
);
  localparam logic [LW-1:0] FULL = LW'(DEPTH);
  localparam int unsigned   NOVF = 3;

  logic rst_n_q;

  fiq_rst_sync u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_q)
  );

  // Watermark decode
  logic [LW-1:0] rx_mark_w, fmt_mark_w;
  assign rx_mark_w  = LW'(rx_mark(rx_thr_code_i));
  assign fmt_mark_w = LW'(fmt_mark(fmt_thr_code_i));

  fiq_thresh #(.LW(LW), .ABOVE(1'b1)) u_rx_thr (
    .clk_i  (clk_i),
    .rst_ni (rst_n_q),
    .lvl_i  (rx_lvl_i),
    .mark_i (rx_mark_w),
    .cond_o (rx_above_o),
    .evt_o  (rx_thr_evt_o)
  );

  fiq_thresh #(.LW(LW), .ABOVE(1'b0)) u_fmt_thr (
    .clk_i  (clk_i),
    .rst_ni (rst_n_q),
    .lvl_i  (fmt_lvl_i),
    .mark_i (fmt_mark_w),
    .cond_o (fmt_below_o),
    .evt_o  (fmt_thr_evt_o)
  );

  // Lost-write detection on command, receive and transmit queues
  logic [NOVF-1:0][LW-1:0] ovf_lvl;
  logic [NOVF-1:0]         ovf_wr;
  logic [NOVF-1:0]         ovf_evt;

  assign ovf_lvl = {tx_lvl_i, rx_lvl_i, fmt_lvl_i};
  assign ovf_wr  = {tx_wr_i, rx_wr_i, fmt_wr_i};

  fiq_ovf #(.N(NOVF), .DEPTH(DEPTH), .LW(LW)) u_ovf (
    .clk_i  (clk_i),
    .rst_ni (rst_n_q),
    .lvl_i  (ovf_lvl),
    .wr_i   (ovf_wr),
    .ovf_o  (ovf_evt)
  );

  assign fmt_ovf_evt_o = ovf_evt[IDX_FMT];
  assign rx_ovf_evt_o  = ovf_evt[IDX_RX];
  assign tx_ovf_evt_o  = ovf_evt[IDX_TX];

  // Acquire-full level and clear strobes
  logic                acq_full_d, acq_full_q;
  logic [NUM_FIFO-1:0] clr_d, clr_q;

  always_comb begin
    acq_full_d = (acq_lvl_i == FULL);
    clr_d      = clr_wr_i ? clr_bits_i : '0;
  end

  always_ff @(posedge clk_i or negedge rst_n_q) begin
    if (!rst_n_q) begin
      acq_full_q <= 1'b0;
      clr_q      <= '0;
    end else begin
      acq_full_q <= acq_full_d;
      clr_q      <= clr_d;
    end
  end

  assign acq_full_o = acq_full_q;
  assign clr_o      = clr_q;
endmodule

// File: rtl/fiq_checker.sv
module fiq_checker #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned LW    = 7
) (
  input logic          clk_i,
  input logic          rst_n,
  input logic [LW-1:0] acq_lvl_i,
  input logic          fmt_wr_i,
  input logic          rx_wr_i,
  input logic          tx_wr_i,
  input logic          clr_wr_i,
  input logic [3:0]    clr_bits_i,
  input logic          rx_above_o,
  input logic          fmt_below_o,
  input logic          rx_thr_evt_o,
  input logic          fmt_thr_evt_o,
  input logic          fmt_ovf_evt_o,
  input logic          rx_ovf_evt_o,
  input logic          tx_ovf_evt_o,
  input logic          acq_full_o,
  input logic [3:0]    clr_o
);
  localparam logic [LW-1:0] FULL = LW'(DEPTH);

  assert_rx_evt_level_R5: assert property (@(posedge clk_i) disable iff (!rst_n)
    rx_thr_evt_o |-> rx_above_o);
  assert_fmt_evt_level_R5: assert property (@(posedge clk_i) disable iff (!rst_n)
    fmt_thr_evt_o |-> fmt_below_o);
  assert_rx_evt_single_R5: assert property (@(posedge clk_i) disable iff (!rst_n)
    rx_thr_evt_o |=> !rx_thr_evt_o);
  assert_fmt_evt_single_R5: assert property (@(posedge clk_i) disable iff (!rst_n)
    fmt_thr_evt_o |=> !fmt_thr_evt_o);
  assert_fmt_ovf_write_R7: assert property (@(posedge clk_i) disable iff (!rst_n)
    fmt_ovf_evt_o |-> $past(fmt_wr_i));
  assert_rx_ovf_write_R7: assert property (@(posedge clk_i) disable iff (!rst_n)
    rx_ovf_evt_o |-> $past(rx_wr_i));
  assert_tx_ovf_write_R7: assert property (@(posedge clk_i) disable iff (!rst_n)
    tx_ovf_evt_o |-> $past(tx_wr_i));
  assert_acq_full_track_R8: assert property (@(posedge clk_i) disable iff (!rst_n)
    acq_full_o == ($past(acq_lvl_i) == FULL));
  assert_clr_after_write_R9: assert property (@(posedge clk_i) disable iff (!rst_n)
    (clr_o != 4'b0) |-> $past(clr_wr_i));
  assert_clr_subset_R9: assert property (@(posedge clk_i) disable iff (!rst_n)
    (clr_o & ~$past(clr_bits_i)) == 4'b0);
endmodule

bind fifo_irq_gen fiq_checker #(.DEPTH(DEPTH), .LW(LW)) u_chk (
  .clk_i         (clk_i),
  .rst_n         (rst_n_q),
  .acq_lvl_i     (acq_lvl_i),
  .fmt_wr_i      (fmt_wr_i),
  .rx_wr_i       (rx_wr_i),
  .tx_wr_i       (tx_wr_i),
  .clr_wr_i      (clr_wr_i),
  .clr_bits_i    (clr_bits_i),
  .rx_above_o    (rx_above_o),
  .fmt_below_o   (fmt_below_o),
  .rx_thr_evt_o  (rx_thr_evt_o),
  .fmt_thr_evt_o (fmt_thr_evt_o),
  .fmt_ovf_evt_o (fmt_ovf_evt_o),
  .rx_ovf_evt_o  (rx_ovf_evt_o),
  .tx_ovf_evt_o  (tx_ovf_evt_o),
  .acq_full_o    (acq_full_o),
  .clr_o         (clr_o)
);

// File: tb/tb_fifo_irq_gen.sv
`timescale 1ns/1ps
module tb_fifo_irq_gen;
  localparam int DEPTH = 64;
  localparam int LW    = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [LW-1:0] fmt_lvl = '0, rx_lvl = '0, tx_lvl = '0, acq_lvl = '0;
  logic          fmt_wr = 1'b0, rx_wr = 1'b0, tx_wr = 1'b0;
  logic [2:0]    rx_code = '0;
  logic [1:0]    fmt_code = '0;
  logic          clr_wr = 1'b0;
  logic [3:0]    clr_bits = '0;

  logic rx_above, fmt_below, rx_evt, fmt_evt, fmt_ovf, rx_ovf, tx_ovf, acq_full;
  logic [3:0] clr;

  fifo_irq_gen #(.DEPTH(DEPTH)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .fmt_lvl_i(fmt_lvl), .rx_lvl_i(rx_lvl), .tx_lvl_i(tx_lvl), .acq_lvl_i(acq_lvl),
    .fmt_wr_i(fmt_wr), .rx_wr_i(rx_wr), .tx_wr_i(tx_wr),
    .rx_thr_code_i(rx_code), .fmt_thr_code_i(fmt_code),
    .clr_wr_i(clr_wr), .clr_bits_i(clr_bits),
    .rx_above_o(rx_above), .fmt_below_o(fmt_below),
    .rx_thr_evt_o(rx_evt), .fmt_thr_evt_o(fmt_evt),
    .fmt_ovf_evt_o(fmt_ovf), .rx_ovf_evt_o(rx_ovf), .tx_ovf_evt_o(tx_ovf),
    .acq_full_o(acq_full), .clr_o(clr)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Advance one edge; sample shortly after it
  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    // R6: state while reset held and after release with empty FIFOs
    #1;
    chk("R6 below in reset", fmt_below, 1);
    chk("R6 above in reset", rx_above, 0);
    rst_n = 1'b1;
    repeat (5) step();
    chk("R6 below", fmt_below, 1);
    chk("R6 above", rx_above, 0);
    chk("R6 fmt evt", fmt_evt, 0);
    chk("R6 rx evt", rx_evt, 0);
    chk("R6 ovf", {tx_ovf, rx_ovf, fmt_ovf}, 0);
    chk("R6 acq full", acq_full, 0);
    chk("R6 clr", clr, 0);
  endtask

  task automatic t_rx_table();
    for (int c = 0; c < 8; c++) begin
      int mark;
      mark = (c == 0) ? 1 : (c == 1) ? 4 : (c == 2) ? 8 : (c == 3) ? 16 : 30; // R1
      rx_code = c[2:0];
      rx_lvl = '0;
      step();
      rx_lvl = mark[LW-1:0];
      step();
      chk($sformatf("R2 at mark code %0d", c), rx_above, 0);
      chk($sformatf("R1 no evt at mark code %0d", c), rx_evt, 0);
      rx_lvl = LW'(mark + 1);
      step();
      chk($sformatf("R2 above code %0d", c), rx_above, 1);
      chk($sformatf("R1 evt code %0d", c), rx_evt, 1);
      step();
      chk($sformatf("R5 rx evt single code %0d", c), rx_evt, 0);
      chk($sformatf("R5 rx level held code %0d", c), rx_above, 1);
      rx_lvl = '0;
      step();
      chk($sformatf("R2 drop code %0d", c), rx_above, 0);
    end
  endtask

  task automatic t_fmt_table();
    for (int c = 0; c < 4; c++) begin
      int mark;
      mark = (c == 0) ? 1 : (c == 1) ? 4 : (c == 2) ? 8 : 16; // R3
      fmt_code = c[1:0];
      fmt_lvl = 7'd40;
      step();
      chk($sformatf("R4 high level code %0d", c), fmt_below, 0);
      fmt_lvl = mark[LW-1:0];
      step();
      chk($sformatf("R4 at mark code %0d", c), fmt_below, 0);
      chk($sformatf("R3 no evt at mark code %0d", c), fmt_evt, 0);
      fmt_lvl = LW'(mark - 1);
      step();
      chk($sformatf("R4 below code %0d", c), fmt_below, 1);
      chk($sformatf("R3 evt code %0d", c), fmt_evt, 1);
      step();
      chk($sformatf("R5 fmt evt single code %0d", c), fmt_evt, 0);
      fmt_lvl = '0;
      step();
      chk($sformatf("R5 no re-fire code %0d", c), fmt_evt, 0);
    end
  endtask

  task automatic t_overflow();
    for (int i = 0; i < 3; i++) begin
      int bitv;
      bitv = 1 << i;
      // R7: full and write attempt
      if (i == 0) begin fmt_lvl = 7'd64; fmt_wr = 1'b1; end
      if (i == 1) begin rx_lvl  = 7'd64; rx_wr  = 1'b1; end
      if (i == 2) begin tx_lvl  = 7'd64; tx_wr  = 1'b1; end
      step();
      chk($sformatf("R7 ovf ch %0d", i), {tx_ovf, rx_ovf, fmt_ovf}, bitv);
      fmt_wr = 1'b0; rx_wr = 1'b0; tx_wr = 1'b0;
      step();
      chk($sformatf("R7 full no write ch %0d", i), {tx_ovf, rx_ovf, fmt_ovf}, 0);
      if (i == 0) begin fmt_lvl = 7'd63; fmt_wr = 1'b1; end
      if (i == 1) begin rx_lvl  = 7'd63; rx_wr  = 1'b1; end
      if (i == 2) begin tx_lvl  = 7'd63; tx_wr  = 1'b1; end
      step();
      chk($sformatf("R7 not full ch %0d", i), {tx_ovf, rx_ovf, fmt_ovf}, 0);
      fmt_wr = 1'b0; rx_wr = 1'b0; tx_wr = 1'b0;
      fmt_lvl = '0; rx_lvl = '0; tx_lvl = '0;
      step();
    end
  endtask

  task automatic t_acq_full();
    acq_lvl = 7'd64;
    step();
    chk("R8 full", acq_full, 1);
    repeat (3) step();
    chk("R8 full held", acq_full, 1);
    acq_lvl = 7'd63;
    step();
    chk("R8 not full", acq_full, 0);
    acq_lvl = '0;
    step();
    chk("R8 empty", acq_full, 0);
  endtask

  task automatic t_clear();
    clr_wr = 1'b1; clr_bits = 4'b0101;
    step();
    chk("R9 strobe", clr, 5);
    clr_wr = 1'b0;
    step();
    chk("R9 self clear", clr, 0);
    clr_bits = 4'b1111;
    step();
    chk("R9 bits ignored without write", clr, 0);
    clr_wr = 1'b1; clr_bits = 4'b1000;
    step();
    chk("R9 acquire strobe", clr, 8);
    clr_wr = 1'b0; clr_bits = 4'b0000;
    step();
    chk("R9 acquire self clear", clr, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_rx_table();
    t_fmt_table();
    t_overflow();
    t_acq_full();
    t_clear();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule